// File: doc/BRIEF.md
# Asynchronous Pulse Catching Synchronizer

This block takes event pulses from a source with no clock relation to the system clock and turns each one into a steady level that a system controller can see on its rising edge. A pulse may be much shorter than a clock period, and such pulses arrive rarely. A small edge-triggered catching cell on each lane latches the event. The caught level then passes through a short register chain on the system clock, and the controller reads it as `level_o`. The level stays up until the controller has acted on the event and pulses `clr_i` for that lane. The asynchronous input never reaches the controller's next-state logic directly.

`NUM_CH` sets the number of independent lanes. `SYNC_STAGES` sets the depth of the register chain. The `MODE` parameter chooses between two variants. In catch mode each lane has a catching cell. In level mode the catching cell is left out: a slow level input feeds the chain directly and the clear has no effect.

Top module: `pulse_catch_sync`

## Requirements
- R1: While `rst_ni` is low, every bit of `level_o` is 0 and the catching cells are held clear, so a pulse that arrives during reset produces no event after reset is released.
- R2: In catch mode, a rising edge on `async_i[i]` raises `level_o[i]`, even when the pulse is narrower than a clock period. The output rises at the second rising clock edge after the pulse edge and always within three clock cycles. It never rises at the first edge.
- R3: In catch mode, once `level_o[i]` is 1 it stays 1 on every clock edge at which `clr_i[i]` is sampled 0.
- R4: In catch mode, when `clr_i[i]` is sampled 1 on a rising edge, `level_o[i]` is 0 from that edge on. It cannot rise again at the following edge.
- R5: In catch mode, several pulses on one lane before a clear give exactly one high period of `level_o[i]`, that is, one event.
- R6: In catch mode, the clear overrides the catching cell. A pulse whose rising edge falls while `clr_i[i]` is high is lost. A pulse that starts after `clr_i[i]` has returned low is caught.
- R7: Lanes are independent. A pulse or a clear on lane i does not change `level_o` of any other lane. A clear on a lane with no pending event leaves its output at 0.
- R8: In level mode, `level_o[i]` equals `async_i[i]` as sampled two rising clock edges earlier, and `clr_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; all sampling happens on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset of cells and chains |
| async_i | input | NUM_CH | Asynchronous event pulses (catch mode) or slow levels (level mode) |
| clr_i | input | NUM_CH | Per-lane single-cycle clear from the controller, synchronous to clk_i |
| level_o | output | NUM_CH | Synchronized held event level per lane |

## Verification
The two functions that can meet in the same cycle are the arrival of a new pulse and the controller's clear of the same lane. The bench provokes this by placing a narrow pulse inside the cycle in which `clr_i` is high, and expects the pulse to be lost and the output to stay low. It then fires a pulse just after the clear drops and expects a normal event two edges later. A scoreboard queue holds one entry for each pulse that must produce an event. Every rising edge of `level_o` must match a queued entry with the right latency, and any rise without a matching entry is reported as an extra event.

// File: rtl/pcs_pkg.sv
`timescale 1ns/1ps
package pcs_pkg;
  typedef enum logic {
    PCS_CATCH = 1'b0,  // pulse input, edge-caught and held until cleared
    PCS_LEVEL = 1'b1   // slow level input, no catching cell
  } pcs_mode_e;
endpackage

// File: rtl/pcs_catch_cell.sv
`timescale 1ns/1ps
module pcs_catch_cell (
  input  logic rst_ni,
  input  logic clr_i,
  input  logic pulse_i,
  output logic caught_o
);
  logic clr_async;

  // clear dominates: an edge while clear is high is dropped
  assign clr_async = clr_i | ~rst_ni;

  always_ff @(posedge pulse_i or posedge clr_async) begin
    if (clr_async) caught_o <= 1'b0;
    else           caught_o <= 1'b1;
  end
endmodule

// File: rtl/pcs_sync_chain.sv
`timescale 1ns/1ps
module pcs_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic d_i,
  output logic q_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    stage_q <= '0;
    else if (clr_i) stage_q <= '0;
    else            stage_q <= {stage_q[LAST-1:0], d_i};
  end

  assign q_o = stage_q[LAST];
endmodule

// File: rtl/pcs_lane.sv
`timescale 1ns/1ps
module pcs_lane #(
  parameter int                 SYNC_STAGES = 2,
  parameter pcs_pkg::pcs_mode_e MODE        = pcs_pkg::PCS_CATCH
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  input  logic clr_i,
  output logic level_o
);
  if (MODE == pcs_pkg::PCS_CATCH) begin : g_catch
    logic caught;

    pcs_catch_cell i_cell (
      .rst_ni   (rst_ni),
      .clr_i    (clr_i),
      .pulse_i  (async_i),
      .caught_o (caught)
    );

    // flushing the chain too drops the output at the clearing edge
    pcs_sync_chain #(.STAGES(SYNC_STAGES)) i_chain (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr_i),
      .d_i    (caught),
      .q_o    (level_o)
    );
  end else begin : g_level
    logic unused_clr;
    assign unused_clr = clr_i;

    pcs_sync_chain #(.STAGES(SYNC_STAGES)) i_chain (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (1'b0),
      .d_i    (async_i),
      .q_o    (level_o)
    );
  end
endmodule

// File: rtl/pulse_catch_sync.sv
`timescale 1ns/1ps
module pulse_catch_sync #(
  parameter int                 NUM_CH      = 2,
  parameter int                 SYNC_STAGES = 2,
  parameter pcs_pkg::pcs_mode_e MODE        = pcs_pkg::PCS_CATCH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] async_i,
  input  logic [NUM_CH-1:0] clr_i,
  output logic [NUM_CH-1:0] level_o
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
    pcs_lane #(
      .SYNC_STAGES (SYNC_STAGES),
      .MODE        (MODE)
    ) i_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (async_i[ch]),
      .clr_i   (clr_i[ch]),
      .level_o (level_o[ch])
    );
  end
endmodule

// File: rtl/pulse_catch_sync_chk.sv
`timescale 1ns/1ps
module pulse_catch_sync_chk #(
  parameter int                 NUM_CH      = 2,
  parameter int                 SYNC_STAGES = 2,
  parameter pcs_pkg::pcs_mode_e MODE        = pcs_pkg::PCS_CATCH
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] async_i,
  input logic [NUM_CH-1:0] clr_i,
  input logic [NUM_CH-1:0] level_o
);
  logic [1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    if (MODE == pcs_pkg::PCS_CATCH) begin : g_catch
      logic unused_async;
      assign unused_async = async_i[ch];

      p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (level_o[ch] && !clr_i[ch]) |=> level_o[ch]);

      p_clear_drops_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i[ch] |=> !level_o[ch]);

      p_no_rise_after_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(level_o[ch]) |-> !$past(clr_i[ch]));
    end else if (SYNC_STAGES == 2) begin : g_level
      p_follow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q >= 2'd2) |-> (level_o[ch] == $past(async_i[ch], 2)));
    end
  end
endmodule

bind pulse_catch_sync pulse_catch_sync_chk #(
  .NUM_CH      (NUM_CH),
  .SYNC_STAGES (SYNC_STAGES),
  .MODE        (MODE)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .async_i (async_i),
  .clr_i   (clr_i),
  .level_o (level_o)
);

// File: tb/test_pulse_catch_sync.sv
`timescale 1ns/1ps
module test_pulse_catch_sync;
  localparam int NCH = 2;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NCH-1:0] async_in;
  logic [NCH-1:0] clr;
  logic [NCH-1:0] level;
  logic [0:0]     lvl_in;
  logic [0:0]     lvl_clr;
  logic [0:0]     lvl_out;

  int n_checks = 0;
  int n_errors = 0;
  int cyc = 0;
  bit done = 1'b0;
  int exp_q[NCH][$];
  logic [NCH-1:0] prev_level = '0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pulse_catch_sync #(.NUM_CH(NCH), .SYNC_STAGES(2), .MODE(pcs_pkg::PCS_CATCH)) i_pulse_catch_sync (
    .clk_i(clk), .rst_ni(rst_n), .async_i(async_in), .clr_i(clr), .level_o(level)
  );

  pulse_catch_sync #(.NUM_CH(1), .SYNC_STAGES(2), .MODE(pcs_pkg::PCS_LEVEL)) i_pulse_catch_sync_lvl (
    .clk_i(clk), .rst_ni(rst_n), .async_i(lvl_in), .clr_i(lvl_clr), .level_o(lvl_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // narrow pulse at the current time; optionally expects one event
  task automatic fire(input int ch, input bit push);
    real w;
    w = 0.5 + $urandom_range(0, 20) / 10.0;
    if (push) exp_q[ch].push_back(cyc);
    async_in[ch] = 1'b1;
    #(w);
    async_in[ch] = 1'b0;
  endtask

  // random phase inside a cycle; returns at the negedge after the next posedge
  task automatic pulse(input int ch, input bit push);
    @(posedge clk);
    #($urandom_range(1, 4));
    fire(ch, push);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear(input int ch);
    @(negedge clk);
    clr[ch] = 1'b1;
    @(negedge clk);
    clr[ch] = 1'b0;
    chk(level[ch] == 1'b0, "R4 level after clear", int'(level[ch]), 0);
  endtask

  // scoreboard monitor: every rise must match a queued pulse
  always @(negedge clk) begin
    for (int ch = 0; ch < NCH; ch++) begin
      if (rst_n && level[ch] && !prev_level[ch]) begin
        if (exp_q[ch].size() == 0) begin
          chk(1'b0, "R5 extra event on lane", ch, -1);
        end else begin
          int lat;
          lat = cyc - exp_q[ch].pop_front();
          chk(lat >= 2 && lat <= 3, "R2 rise latency", lat, 2);
        end
      end
    end
    prev_level = level;
  end

  initial begin
    rst_n = 1'b0; async_in = '0; clr = '0; lvl_in = '0; lvl_clr = '0;
    repeat (3) @(negedge clk);
    chk(level == '0, "R1 level in reset", int'(level), 0);
    @(posedge clk); #2;
    fire(0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(level == '0, "R1 pulse in reset discarded", int'(level), 0);

    // random lanes, phases and widths
    for (int it = 0; it < 16; it++) begin
      int ch;
      ch = $urandom_range(0, NCH - 1);
      pulse(ch, 1'b1);
      chk(level[ch] == 1'b0, "R2 not at first edge", int'(level[ch]), 0);
      @(negedge clk);
      chk(level[ch] == 1'b1, "R2 level raised", int'(level[ch]), 1);
      repeat ($urandom_range(0, 6)) @(negedge clk);
      chk(level[ch] == 1'b1, "R3 level held", int'(level[ch]), 1);
      chk(level[1-ch] == 1'b0, "R7 other lane untouched", int'(level[1-ch]), 0);
      clear(ch);
    end

    // several pulses merge into one event
    pulse(0, 1'b1);
    pulse(0, 1'b0);
    pulse(0, 1'b0);
    @(negedge clk);
    chk(level[0] == 1'b1, "R5 merged event high", int'(level[0]), 1);
    clear(0);
    repeat (4) @(negedge clk);
    chk(level[0] == 1'b0, "R5 no second event", int'(level[0]), 0);

    // pulse inside the clear cycle is lost
    @(negedge clk);
    clr[1] = 1'b1;
    #1;
    fire(1, 1'b0);
    @(negedge clk);
    clr[1] = 1'b0;
    repeat (4) @(negedge clk);
    chk(level[1] == 1'b0, "R6 pulse during clear lost", int'(level[1]), 0);

    // pulse just after the clear drops is caught
    @(negedge clk);
    clr[1] = 1'b1;
    @(negedge clk);
    clr[1] = 1'b0;
    #1;
    fire(1, 1'b1);
    @(negedge clk);
    @(negedge clk);
    chk(level[1] == 1'b1, "R6 pulse after clear caught", int'(level[1]), 1);
    clear(1);

    // lane independence and clear with nothing pending
    pulse(0, 1'b1);
    pulse(1, 1'b1);
    @(negedge clk);
    chk(level == 2'b11, "R7 both lanes high", int'(level), 3);
    clear(0);
    chk(level[1] == 1'b1, "R7 clear of lane 0 spares lane 1", int'(level[1]), 1);
    clear(1);
    clear(0);
    repeat (2) @(negedge clk);
    chk(level == '0, "R7 idle clear no effect", int'(level), 0);

    // level mode: two-edge delay, clear ignored
    @(negedge clk);
    lvl_in = 1'b1;
    lvl_clr = 1'b1;
    @(negedge clk);
    lvl_clr = 1'b0;
    chk(lvl_out == 1'b0, "R8 one edge not enough", int'(lvl_out), 0);
    @(negedge clk);
    chk(lvl_out == 1'b1, "R8 follows after two edges", int'(lvl_out), 1);
    lvl_clr = 1'b1;
    @(negedge clk);
    lvl_clr = 1'b0;
    @(negedge clk);
    chk(lvl_out == 1'b1, "R8 clear ignored", int'(lvl_out), 1);
    lvl_in = 1'b0;
    @(negedge clk);
    chk(lvl_out == 1'b1, "R8 fall delayed", int'(lvl_out), 1);
    @(negedge clk);
    chk(lvl_out == 1'b0, "R8 fall after two edges", int'(lvl_out), 0);

    repeat (4) @(negedge clk);
    for (int ch = 0; ch < NCH; ch++)
      chk(exp_q[ch].size() == 0, "R2 every pulse produced an event", exp_q[ch].size(), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end
endmodule